// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column address of a single SDRAM read or write burst. A start strobe loads a starting column together with the burst length code and the burst ordering bit taken from the mode register. From the next clock on, the block presents one column per cycle, with a valid flag and a flag on the final beat, until the burst runs out.

Two orderings are supported inside an aligned block of burst-length columns. Sequential order counts upward and wraps inside the block. Interleaved order flips low address bits according to the beat number. A page-long mode is also supported, but only with sequential order: it cycles through all 512 columns of a row and never ends by itself. A stop input ends a burst at once. A fresh start on any cycle, including the cycle right after another start, drops the running burst and begins the new one. Length codes that are not legal produce a one-beat burst and raise an error flag.

Top module: `col_burst_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `valid_o`, `last_o` and `bad_code_o` are 0.
- R2: A start sampled at a clock edge makes `valid_o` 1 and `col_o` equal to the start column right after that edge (beat 0).
- R3: Length code 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. `valid_o` stays high for exactly that many cycles, `last_o` is high on the final beat only, and `valid_o` drops on the cycle after the final beat unless a new start arrives.
- R4: With `burst_type_i` = 0 (sequential), beat i has the start column's bits above the low log2(BL) bits unchanged, and the low log2(BL) bits equal (start low bits + i) mod BL.
- R5: With `burst_type_i` = 1 (interleaved), beat i has the same upper bits as the start column, and the low log2(BL) bits equal the start low bits XOR i.
- R6: Code 3'b111 with `burst_type_i` = 0 is a page burst. Beat i is (start + i) mod 512, so column 511 is followed by 0. `last_o` is never raised, and the burst runs until it is stopped or restarted.
- R7: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with `burst_type_i` = 1, are reserved. Such a start gives a one-beat burst at the start column, and `bad_code_o` goes high from that beat. It stays high until the next start with a legal code, which clears it.
- R8: `stop_i` without `start_i` makes `valid_o` 0 after the edge. When no burst is running, `stop_i` has no effect.
- R9: A start while a burst runs abandons it: the next cycle shows beat 0 of the new burst, with its own length and order. When `start_i` and `stop_i` are high together, the start wins.
- R10: Starts on consecutive cycles are each accepted, and each shows its own start column on the following cycle.
- R11: `last_o` is never high while `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a new burst this cycle |
| start_col_i | input | 9 | Starting column of the burst |
| len_code_i | input | 3 | Burst length code from the mode register |
| burst_type_i | input | 1 | 0 = sequential order, 1 = interleaved order |
| stop_i | input | 1 | End the running burst now |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | The current beat is the final one |
| bad_code_o | output | 1 | The most recent start carried a reserved length code |

## Verification
The bench builds the block with its default 9-bit column width, the full 512-word page. With that width, the page burst's wrap from column 511 to 0 is reached within a few beats when the burst starts near the top of the page. Starting columns are chosen so that sequential bursts wrap inside their aligned block, and so that interleaved bursts start off alignment and their XOR pattern shows. Restarts, stops and starts paired with a stop are placed mid-burst, where they cut an unfinished sequence.

// File: rtl/cbg_pkg.sv
package cbg_pkg;

    localparam int COL_W         = 9;
    localparam int CODE_W        = 3;
    localparam int MAX_FIXED_LOG = 3;

    typedef logic [COL_W-1:0]  col_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

    typedef struct packed {
        col_t   mask;
        logic   endless;
        logic   bad;
        order_e order;
    } burst_cfg_t;

    localparam code_t CODE_PAGE = code_t'(7);

    function automatic burst_cfg_t decode_len(code_t code, order_e ord);
        burst_cfg_t c;
        c.order   = ord;
        c.endless = 1'b0;
        c.bad     = 1'b0;
        c.mask    = '0;
        if (code <= code_t'(MAX_FIXED_LOG)) begin
            c.mask = col_t'((1 << code) - 1);
        end else if (code == CODE_PAGE && ord == ORD_SEQ) begin
            c.mask    = '1;
            c.endless = 1'b1;
        end else begin
            c.bad   = 1'b1;
            c.order = ORD_SEQ;
        end
        return c;
    endfunction

    function automatic col_t beat_col(col_t base, col_t idx, col_t mask, order_e ord);
        col_t low;
        if (ord == ORD_XOR) low = base ^ idx;
        else                low = base + idx;
        return (base & ~mask) | (low & mask);
    endfunction

endpackage

// File: rtl/cbg_len_decode.sv
module cbg_len_decode
    import cbg_pkg::*;
(
    input  code_t      code_i,
    input  order_e     order_i,
    output burst_cfg_t cfg_o
);

    assign cfg_o = decode_len(code_i, order_i);

    always_comb begin
        if (!$isunknown({code_i, order_i})) begin
            p_mask_pow2_r3: assert ($countones({1'b0, cfg_o.mask} + (COL_W+1)'(1)) == 1)
                else $error("burst mask is not one below a power of two");
            p_page_seq_only_r6: assert (!(cfg_o.endless && cfg_o.order == ORD_XOR))
                else $error("page burst with interleaved order");
        end
    end

endmodule

// File: rtl/cbg_beat_ctr.sv
module cbg_beat_ctr
    import cbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       stop_i,
    input  col_t       base_i,
    input  burst_cfg_t cfg_i,
    output logic       active_o,
    output col_t       idx_o,
    output col_t       base_o,
    output burst_cfg_t cfg_o,
    output logic       last_o
);

    logic       act_q;
    col_t       idx_q;
    col_t       base_q;
    burst_cfg_t cfg_q;
    logic       final_beat;

    assign final_beat = act_q && !cfg_q.endless && (idx_q == cfg_q.mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
            cfg_q  <= '0;
        end else if (start_i) begin
            act_q  <= 1'b1;
            idx_q  <= '0;
            base_q <= base_i;
            cfg_q  <= cfg_i;
        end else if (stop_i || final_beat) begin
            act_q  <= 1'b0;
        end else if (act_q) begin
            idx_q  <= idx_q + col_t'(1);
        end
    end

    assign active_o = act_q;
    assign idx_o    = idx_q;
    assign base_o   = base_q;
    assign cfg_o    = cfg_q;
    assign last_o   = final_beat;

    p_stop_r8: assert property (@(posedge clk) disable iff (rst)
        stop_i && !start_i |=> !active_o)
        else $error("stop did not end the burst");

    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        start_i |=> active_o && idx_o == '0 && base_o == $past(base_i))
        else $error("start did not reload beat 0");

    p_end_r3: assert property (@(posedge clk) disable iff (rst)
        last_o && !start_i |=> !active_o)
        else $error("burst ran past its final beat");

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        active_o && !last_o && !start_i && !stop_i |=> active_o && idx_o == $past(idx_o) + col_t'(1))
        else $error("beat index did not advance by one");

endmodule

// File: rtl/cbg_addr_unit.sv
module cbg_addr_unit
    import cbg_pkg::*;
(
    input  col_t       base_i,
    input  col_t       idx_i,
    input  burst_cfg_t cfg_i,
    output col_t       col_o
);

    assign col_o = beat_col(base_i, idx_i, cfg_i.mask, cfg_i.order);

    always_comb begin
        if (!$isunknown({base_i, idx_i, cfg_i})) begin
            p_block_kept_r5: assert ((col_o & ~cfg_i.mask) == (base_i & ~cfg_i.mask))
                else $error("column left its aligned block");
        end
    end

endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen
    import cbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [CODE_W-1:0] len_code_i,
    input  logic             burst_type_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             bad_code_o
);

    burst_cfg_t new_cfg;
    burst_cfg_t cur_cfg;
    col_t       cur_base;
    col_t       cur_idx;
    logic       active;
    logic       final_beat;

    cbg_len_decode u_dec (
        .code_i  (len_code_i),
        .order_i (order_e'(burst_type_i)),
        .cfg_o   (new_cfg)
    );

    cbg_beat_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .base_i   (start_col_i),
        .cfg_i    (new_cfg),
        .active_o (active),
        .idx_o    (cur_idx),
        .base_o   (cur_base),
        .cfg_o    (cur_cfg),
        .last_o   (final_beat)
    );

    cbg_addr_unit u_addr (
        .base_i (cur_base),
        .idx_i  (cur_idx),
        .cfg_i  (cur_cfg),
        .col_o  (col_o)
    );

    assign valid_o    = active;
    assign last_o     = final_beat;
    assign bad_code_o = cur_cfg.bad;

    p_last_valid_r11: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o)
        else $error("last without valid");

    p_load_col_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o && col_o == $past(start_col_i))
        else $error("beat 0 is not the start column");

    p_page_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        valid_o && cur_cfg.endless && !start_i && !stop_i |=> valid_o && !last_o && col_o == $past(col_o) + col_t'(1))
        else $error("page burst did not step by one");

    p_bad_set_r7: assert property (@(posedge clk) disable iff (rst)
        start_i && (len_code_i inside {3'd4, 3'd5, 3'd6} || (len_code_i == 3'd7 && burst_type_i))
        |=> bad_code_o && last_o)
        else $error("reserved code not flagged");

    p_bad_clear_r7: assert property (@(posedge clk) disable iff (rst)
        start_i && len_code_i <= 3'd3 |=> !bad_code_o)
        else $error("legal code left error flag set");

endmodule

// File: tb/sim_col_burst_gen.sv
module sim_col_burst_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       burst_type_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       last_o;
    logic       bad_code_o;

    col_burst_gen u0 (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_col_i  (start_col_i),
        .len_code_i   (len_code_i),
        .burst_type_i (burst_type_i),
        .stop_i       (stop_i),
        .col_o        (col_o),
        .valid_o      (valid_o),
        .last_o       (last_o),
        .bad_code_o   (bad_code_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit       v;
        bit [8:0] col;
        bit       last;
        bit       bad;
        string    req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;

    // reference model state
    bit       m_act = 0, m_full = 0, m_ilv = 0, m_bad = 0;
    int       m_len = 1, m_idx = 0;
    bit [8:0] m_base = 0;

    task automatic check(bit ok, string req, string what, int got, int want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, want);
        end
    endtask

    task automatic cyc(bit st, bit [8:0] c, bit [2:0] code, bit typ, bit sp, string req);
        exp_t e;
        int   span, blk, off, colv;
        @(negedge clk);
        start_i = st; start_col_i = c; len_code_i = code; burst_type_i = typ; stop_i = sp;
        if (st) begin
            m_act = 1; m_base = c; m_idx = 0; m_full = 0; m_bad = 0; m_ilv = typ;
            if (code <= 3) m_len = 1 << code;
            else if (code == 7 && !typ) m_full = 1;
            else begin m_len = 1; m_bad = 1; m_ilv = 0; end
        end else if (sp) begin
            m_act = 0;
        end else if (m_act) begin
            if (!m_full && m_idx == m_len - 1) m_act = 0;
            else m_idx++;
        end
        span = m_full ? 512 : m_len;
        off  = int'(m_base) % span;
        blk  = int'(m_base) - off;
        if (m_ilv) colv = blk + (off ^ m_idx);
        else       colv = blk + ((off + m_idx) % span);
        e.v    = m_act;
        e.col  = colv[8:0];
        e.last = m_act && !m_full && (m_idx == m_len - 1);
        e.bad  = m_bad;
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++) cyc(0, 9'd0, 3'd0, 1'b0, 1'b0, req);
    endtask

    // monitor: pops one expectation per edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                check(valid_o == e.v, e.req, "valid_o", int'(valid_o), int'(e.v));
                if (e.v) check(col_o == e.col, e.req, "col_o", int'(col_o), int'(e.col));
                // R11: last only on a valid final beat
                check(last_o == e.last, e.req, "last_o", int'(last_o), int'(e.last));
                check(bad_code_o == e.bad, e.req, "bad_code_o", int'(bad_code_o), int'(e.bad));
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(valid_o == 0, "R1", "valid_o in reset", int'(valid_o), 0);
        check(last_o == 0, "R1", "last_o in reset", int'(last_o), 0);
        check(bad_code_o == 0, "R1", "bad_code_o in reset", int'(bad_code_o), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(valid_o == 0 && bad_code_o == 0, "R1", "idle after reset", int'(valid_o), 0);

        // R2, R4: sequential length 4 from column 6 -> 6,7,4,5
        cyc(1, 9'd6, 3'd2, 1'b0, 1'b0, "R2");
        idle(4, "R4");
        // R5: interleaved length 8 from 5 -> 5,4,7,6,1,0,3,2
        cyc(1, 9'd5, 3'd3, 1'b1, 1'b0, "R5");
        idle(8, "R5");
        // R3: length 1 and length 2
        cyc(1, 9'h1AB, 3'd0, 1'b0, 1'b0, "R3");
        idle(2, "R3");
        cyc(1, 9'h0FF, 3'd1, 1'b1, 1'b0, "R3");
        idle(3, "R3");
        cyc(1, 9'h0C9, 3'd3, 1'b0, 1'b0, "R4");
        idle(9, "R3");
        // R6: page burst wrapping 509 -> 0
        cyc(1, 9'd509, 3'd7, 1'b0, 1'b0, "R6");
        idle(6, "R6");
        cyc(0, 9'd0, 3'd0, 1'b0, 1'b1, "R8");
        idle(2, "R8");
        // R7: reserved codes
        cyc(1, 9'h040, 3'd5, 1'b0, 1'b0, "R7");
        idle(3, "R7");
        cyc(1, 9'h033, 3'd7, 1'b1, 1'b0, "R7");
        idle(2, "R7");
        cyc(1, 9'h010, 3'd1, 1'b0, 1'b0, "R7");
        idle(3, "R7");
        // R9: restart mid burst
        cyc(1, 9'h020, 3'd3, 1'b0, 1'b0, "R9");
        idle(2, "R9");
        cyc(1, 9'h047, 3'd2, 1'b1, 1'b0, "R9");
        idle(5, "R9");
        // R10: back-to-back starts
        cyc(1, 9'd1, 3'd3, 1'b0, 1'b0, "R10");
        cyc(1, 9'd2, 3'd3, 1'b0, 1'b0, "R10");
        cyc(1, 9'd3, 3'd1, 1'b1, 1'b0, "R10");
        idle(3, "R10");
        // R8: stop while idle does nothing
        cyc(0, 9'h055, 3'd3, 1'b0, 1'b1, "R8");
        idle(1, "R8");
        // R9: start together with stop
        cyc(1, 9'h007, 3'd2, 1'b0, 1'b1, "R9");
        idle(5, "R9");
        // R8: stop in the middle of a sequential length-8 burst
        cyc(1, 9'h100, 3'd3, 1'b0, 1'b0, "R8");
        idle(2, "R8");
        cyc(0, 9'd0, 3'd0, 1'b0, 1'b1, "R8");
        idle(2, "R8");

        repeat (2) @(posedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule